// File: doc/BRIEF.md
# Asynchronous Static Memory Timing Controller

This block sits between an internal request port and external asynchronous memories such as SRAM, flash or ROM. Each accepted request names a 32-bit byte address, a direction, a 16-bit write value and whether the request is 16 bits wide. The top address byte is compared against four region decoders; the winning region selects one chip-select line and one of two timing sets (read or write), each holding four five-bit cycle counts.

The external cycle is a fixed sequence of phases: setup, access, hold, and a turnaround gap during which the data bus is left undriven. Chip select, output enable, write enable and the bus drive control are decoded from the phase. An 8-bit device is served by splitting a 16-bit request into two complete byte sequences. A request that hits no region is answered with an error and no external cycle. The configuration is presented on plain input ports and is expected to stay stable while a request is in flight.

Top module: `static_mem_ctrl`

## Requirements
- R1: Region k matches when (address[31:24] & mask_k) == locate_k; with mask and locate both zero, a region matches every address.
- R2: When several regions match, the lowest-numbered one is used; an address matching none is answered one cycle after acceptance with rsp_err = 1, no chip select asserted and no strobe.
- R3: A sequence runs setup, access, hold, turnaround in that order, each lasting its programmed number of cycles; a count of zero skips the phase, except access, which lasts at least one cycle.
- R4: Reads use the read timing set of the selected region and writes its write timing set; timing fields in each 20-bit slot are packed as setup [19:15], access [14:10], hold [9:5], turnaround [4:0], slot k at bits [20k+19:20k].
- R5: During a read, the selected active-low chip select is low through setup, access and hold, output enable is low during setup and access only, and write enable stays high.
- R6: During a write, the bus drive control is high from the first setup cycle to the last hold cycle, write enable is low only during access, and output enable stays high.
- R7: Read data is captured from the data input on the last access cycle and returned on rsp_rdata.
- R8: Width bit 0 marks an 8-bit device, 1 a 16-bit device; a 16-bit request to an 8-bit device runs two full sequences, the low byte at the request address first and the high byte at the next address, each byte on data bits [7:0]; a narrow read returns zero in bits [15:8].
- R9: req_ready is high only while no request is in progress; rsp_valid is a one-cycle pulse in the cycle after the final turnaround cycle, giving a latency of n·(S+max(A,1)+H+T)+1 cycles after acceptance, with n sequences.
- R10: After reset all chip selects, output enable and write enable are high, the bus is not driven, req_ready is high and rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken when valid |
| req_addr | input | 32 | Byte address |
| req_we | input | 1 | 1 for write, 0 for read |
| req_wide | input | 1 | 1 for a 16-bit request |
| req_wdata | input | 16 | Write value |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Address hit no region |
| rsp_rdata | output | 16 | Read result |
| cfg_rd_time | input | 80 | Read timing slots, one 20-bit slot per region |
| cfg_wr_time | input | 80 | Write timing slots, one 20-bit slot per region |
| cfg_mask | input | 32 | Decode masks, 8 bits per region |
| cfg_locate | input | 32 | Decode locate values, 8 bits per region |
| cfg_wide | input | 4 | Device width per region |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_addr | output | 32 | External address |
| mem_dout | output | 16 | Data to drive onto the bus |
| mem_doe | output | 1 | Bus drive enable |
| mem_din | input | 16 | Data read from the bus |

## Verification
The assertions watch, on every cycle, that at most one chip select is low, that write enable and output enable never overlap, that write enable only appears with the bus driven under an active chip select, that the bus is never driven while output enable is low, and that completion is a single-cycle pulse with no external activity on an error. Phase lengths, skipped zero phases, the latency formula, region priority, byte splitting order and captured read data can only be shown by the bench's transactions, which count strobe cycles and log bus values against a model of the memory.

// File: rtl/static_mem_ctrl.sv
module static_mem_ctrl #(
  parameter int N_CS = 4,
  parameter int AW   = 32,
  parameter int TW   = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [AW-1:0]         req_addr,
  input  logic                  req_we,
  input  logic                  req_wide,
  input  logic [15:0]           req_wdata,
  output logic                  rsp_valid,
  output logic                  rsp_err,
  output logic [15:0]           rsp_rdata,
  input  logic [N_CS*4*TW-1:0]  cfg_rd_time,
  input  logic [N_CS*4*TW-1:0]  cfg_wr_time,
  input  logic [N_CS*8-1:0]     cfg_mask,
  input  logic [N_CS*8-1:0]     cfg_locate,
  input  logic [N_CS-1:0]       cfg_wide,
  output logic [N_CS-1:0]       mem_cs_n,
  output logic                  mem_oe_n,
  output logic                  mem_we_n,
  output logic [AW-1:0]         mem_addr,
  output logic [15:0]           mem_dout,
  output logic                  mem_doe,
  input  logic [15:0]           mem_din
);

  localparam int CSW = (N_CS > 1) ? $clog2(N_CS) : 1;
  localparam int TS  = 4 * TW;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_ACCESS, PH_HOLD, PH_TURN, PH_DONE
  } phase_t;

  phase_t         state;
  logic [TW-1:0]  cnt;
  logic [CSW-1:0] cs_sel;
  logic           is_wr, split, second, err_q;
  logic [AW-1:0]  addr_q;
  logic [15:0]    wdata_q, rdata_q;

  logic           hit;
  logic [CSW-1:0] hit_idx;

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int k = N_CS - 1; k >= 0; k--) begin
      if ((req_addr[AW-1 -: 8] & cfg_mask[k*8 +: 8]) == cfg_locate[k*8 +: 8]) begin
        hit     = 1'b1;
        hit_idx = CSW'(k);
      end
    end
  end

  logic [CSW-1:0] t_idx;
  logic           t_wr;
  logic [TS-1:0]  tset;
  logic [TW-1:0]  t_setup, t_acc, t_hold, t_turn, acc_len;

  assign t_idx   = (state == PH_IDLE) ? hit_idx : cs_sel;
  assign t_wr    = (state == PH_IDLE) ? req_we  : is_wr;
  assign tset    = t_wr ? cfg_wr_time[int'(t_idx)*TS +: TS] : cfg_rd_time[int'(t_idx)*TS +: TS];
  assign t_setup = tset[4*TW-1 -: TW];
  assign t_acc   = tset[3*TW-1 -: TW];
  assign t_hold  = tset[2*TW-1 -: TW];
  assign t_turn  = tset[TW-1:0];
  assign acc_len = (t_acc == '0) ? TW'(1) : t_acc;

  phase_t        start_ph, end_ph, turn_ph, hold_ph, lv_ph;
  logic [TW-1:0] start_cnt, end_cnt, turn_cnt, hold_cnt, lv_cnt;
  logic          more, lv_restart;

  assign more = split && !second;

  always_comb begin
    start_ph  = (t_setup != '0) ? PH_SETUP : PH_ACCESS;
    start_cnt = (t_setup != '0) ? t_setup - TW'(1) : acc_len - TW'(1);
    end_ph    = more ? start_ph  : PH_DONE;
    end_cnt   = more ? start_cnt : '0;
    turn_ph   = (t_turn != '0) ? PH_TURN : end_ph;
    turn_cnt  = (t_turn != '0) ? t_turn - TW'(1) : end_cnt;
    hold_ph   = (t_hold != '0) ? PH_HOLD : turn_ph;
    hold_cnt  = (t_hold != '0) ? t_hold - TW'(1) : turn_cnt;
    lv_ph      = PH_IDLE;
    lv_cnt     = '0;
    lv_restart = 1'b0;
    case (state)
      PH_SETUP: begin
        lv_ph  = PH_ACCESS;
        lv_cnt = acc_len - TW'(1);
      end
      PH_ACCESS: begin
        lv_ph      = hold_ph;
        lv_cnt     = hold_cnt;
        lv_restart = more && (t_hold == '0) && (t_turn == '0);
      end
      PH_HOLD: begin
        lv_ph      = turn_ph;
        lv_cnt     = turn_cnt;
        lv_restart = more && (t_turn == '0);
      end
      PH_TURN: begin
        lv_ph      = end_ph;
        lv_cnt     = end_cnt;
        lv_restart = more;
      end
      default: ;
    endcase
  end

  logic narrow;
  assign narrow = !cfg_wide[cs_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= PH_IDLE;
      cnt     <= '0;
      cs_sel  <= '0;
      is_wr   <= 1'b0;
      split   <= 1'b0;
      second  <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (state)
        PH_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          is_wr   <= req_we;
          rdata_q <= '0;
          second  <= 1'b0;
          cs_sel  <= hit_idx;
          err_q   <= !hit;
          split   <= req_wide && !cfg_wide[hit_idx];
          state   <= hit ? start_ph : PH_DONE;
          cnt     <= hit ? start_cnt : '0;
        end
        PH_DONE: state <= PH_IDLE;
        default: begin
          if (cnt == '0) begin
            state <= lv_ph;
            cnt   <= lv_cnt;
            if (lv_restart) second <= 1'b1;
            if (state == PH_ACCESS && !is_wr) begin
              if (!narrow)     rdata_q        <= mem_din;
              else if (second) rdata_q[15:8]  <= mem_din[7:0];
              else             rdata_q[7:0]   <= mem_din[7:0];
            end
          end else begin
            cnt <= cnt - TW'(1);
          end
        end
      endcase
    end
  end

  logic on_bus;
  assign on_bus    = (state == PH_SETUP) || (state == PH_ACCESS) || (state == PH_HOLD);
  assign mem_cs_n  = on_bus ? ~(N_CS'(1) << cs_sel) : '1;
  assign mem_oe_n  = !(!is_wr && (state == PH_SETUP || state == PH_ACCESS));
  assign mem_we_n  = !(is_wr && state == PH_ACCESS);
  assign mem_doe   = is_wr && on_bus;
  assign mem_addr  = addr_q + {{(AW-1){1'b0}}, second};
  assign mem_dout  = !narrow ? wdata_q : {8'h00, second ? wdata_q[15:8] : wdata_q[7:0]};
  assign req_ready = (state == PH_IDLE);
  assign rsp_valid = (state == PH_DONE);
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~mem_cs_n) <= 1);                                            // R2
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));                                             // R5
  AST_WE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_doe && mem_cs_n != '1));                             // R6
  AST_NO_DRIVE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_doe |-> mem_oe_n);                                                  // R6
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);                                              // R9
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs_n != '1) |-> !req_ready);                                       // R9
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (mem_cs_n == '1 && $past(mem_cs_n) == '1));  // R2

endmodule

// File: tb/test_static_mem_ctrl.sv
module test_static_mem_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0, req_wide = 1'b0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;
  logic [3:0]  mem_cs_n;
  logic        mem_oe_n, mem_we_n, mem_doe;
  logic [31:0] mem_addr;
  logic [15:0] mem_dout, mem_din;

  logic [19:0] rt [4];
  logic [19:0] wt [4];
  logic [7:0]  msk [4];
  logic [7:0]  loc [4];
  logic [3:0]  wid;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  function automatic logic [15:0] din_of(input logic [31:0] a);
    return {a[7:0] ^ 8'hA5, a[7:0] ^ 8'h3C};
  endfunction

  assign mem_din = din_of(mem_addr);

  static_mem_ctrl i_static_mem_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_we(req_we), .req_wide(req_wide), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .cfg_rd_time({rt[3], rt[2], rt[1], rt[0]}),
    .cfg_wr_time({wt[3], wt[2], wt[1], wt[0]}),
    .cfg_mask({msk[3], msk[2], msk[1], msk[0]}),
    .cfg_locate({loc[3], loc[2], loc[1], loc[0]}),
    .cfg_wide(wid),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_din(mem_din)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_cs(input logic [7:0] top);
    for (int k = 0; k < 4; k++)
      if ((top & msk[k]) == loc[k]) return k;
    return -1;
  endfunction

  task automatic run(input logic [31:0] a, input logic we, input logic wide, input logic [15:0] wd);
    int ecs, n, k, s, ac, h, t;
    int c_cs, c_oe, c_we, c_doe, c_rdy, nw;
    logic [3:0] seen;
    logic [19:0] ts;
    logic done, gerr, pwe;
    logic [15:0] grd, lo, hi, erd;
    logic [31:0] waddr [2];
    logic [15:0] wdat [2];
    logic [31:0] paddr;
    ecs = exp_cs(a[31:24]);
    ts  = (ecs < 0) ? 20'h0 : (we ? wt[ecs] : rt[ecs]);
    s = int'(ts[19:15]); ac = (ts[14:10] == 0) ? 1 : int'(ts[14:10]);
    h = int'(ts[9:5]);   t = int'(ts[4:0]);
    n = (ecs >= 0 && wide && !wid[ecs]) ? 2 : 1;
    c_cs = 0; c_oe = 0; c_we = 0; c_doe = 0; c_rdy = 0; nw = 0; seen = '0;
    done = 1'b0; gerr = 1'b0; grd = '0; pwe = 1'b1; paddr = '0; k = 0;
    waddr[0] = '0; waddr[1] = '0; wdat[0] = '0; wdat[1] = '0;
    @(negedge clk);
    req_addr = a; req_we = we; req_wide = wide; req_wdata = wd; req_valid = 1'b1;
    @(posedge clk);
    while (!done && k < 3000) begin
      @(negedge clk);
      req_valid = 1'b0;
      k++;
      if (mem_cs_n != 4'hF) c_cs++;
      if (!mem_oe_n) c_oe++;
      if (!mem_we_n) c_we++;
      if (mem_doe) c_doe++;
      if (req_ready) c_rdy++;
      seen |= ~mem_cs_n;
      if (!mem_we_n && (pwe || mem_addr != paddr) && nw < 2) begin
        waddr[nw] = mem_addr; wdat[nw] = mem_dout; nw++;
      end
      pwe = mem_we_n; paddr = mem_addr;
      if (rsp_valid) begin done = 1'b1; gerr = rsp_err; grd = rsp_rdata; end
    end
    chk("R9 completion seen", 32'(done), 32'd1);
    if (ecs < 0) begin
      chk("R2 miss latency", 32'(k), 32'd1);
      chk("R2 miss error flag", 32'(gerr), 32'd1);
      chk("R2 miss no chip select", 32'(seen), 32'd0);
      return;
    end
    chk("R9 latency", 32'(k), 32'(n * (s + ac + h + t) + 1));
    chk("R9 not ready while busy", 32'(c_rdy), 32'd0);
    chk("R2 no error on hit", 32'(gerr), 32'd0);
    chk("R1 selected chip select", 32'(seen), 32'(4'b0001 << ecs));
    chk("R3 chip select cycles", 32'(c_cs), 32'(n * (s + ac + h)));
    if (!we) begin
      chk("R5 output enable cycles", 32'(c_oe), 32'(n * (s + ac)));
      chk("R5 write enable idle on read", 32'(c_we), 32'd0);
      lo = din_of(a); hi = din_of(a + 32'd1);
      if (wid[ecs]) erd = lo;
      else if (n == 2) erd = {hi[7:0], lo[7:0]};
      else erd = {8'h00, lo[7:0]};
      chk("R7 read data", 32'(grd), 32'(erd));
    end else begin
      chk("R6 write enable cycles", 32'(c_we), 32'(n * ac));
      chk("R6 drive cycles", 32'(c_doe), 32'(n * (s + ac + h)));
      chk("R6 output enable idle on write", 32'(c_oe), 32'd0);
      chk("R8 write events", 32'(nw), 32'(n));
      chk("R8 first write address", waddr[0], a);
      chk("R8 first write data", 32'(wdat[0]), wid[ecs] ? 32'(wd) : 32'(wd[7:0]));
      if (n == 2) begin
        chk("R8 second write address", waddr[1], a + 32'd1);
        chk("R8 second write data", 32'(wdat[1]), 32'(wd[15:8]));
      end
    end
  endtask

  function automatic logic [19:0] tm(input int s, input int a, input int h, input int t);
    return {5'(s), 5'(a), 5'(h), 5'(t)};
  endfunction

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] tops [6];
    void'($urandom(32'd20240611));
    for (int k = 0; k < 4; k++) begin
      rt[k] = '0; wt[k] = '0; msk[k] = '0; loc[k] = '0;
    end
    wid = 4'h0;
    repeat (3) @(negedge clk);
    chk("R10 chip selects", 32'(mem_cs_n), 32'hF);
    chk("R10 strobes", 32'({mem_oe_n, mem_we_n, mem_doe}), 32'b110);
    chk("R10 handshake", 32'({req_ready, rsp_valid}), 32'b10);
    rst_n = 1'b1;

    // R1 R3: all-zero settings, region 0 covers everything, access still one cycle
    run(32'h1234_5678, 1'b0, 1'b0, 16'h0);
    run(32'hFEDC_0010, 1'b1, 1'b0, 16'hBEEF);
    // R8 R3: split with every phase zero
    run(32'h0000_4000, 1'b0, 1'b1, 16'h0);
    run(32'h0000_4002, 1'b1, 1'b1, 16'hC3A1);

    msk[0] = 8'hFF; loc[0] = 8'h10;
    msk[1] = 8'hF0; loc[1] = 8'h20;
    msk[2] = 8'hFF; loc[2] = 8'h2F;
    msk[3] = 8'h80; loc[3] = 8'h80;
    wid = 4'b0101;
    rt[0] = tm(2, 3, 1, 2); wt[0] = tm(1, 4, 2, 0);
    rt[1] = tm(0, 2, 0, 3); wt[1] = tm(3, 0, 0, 0);
    rt[2] = tm(1, 1, 1, 1); wt[2] = tm(1, 1, 1, 1);
    rt[3] = tm(1, 2, 3, 0); wt[3] = tm(0, 1, 2, 1);

    // R4: same region, distinct read and write sets
    run(32'h1000_0100, 1'b0, 1'b1, 16'h0);
    run(32'h1000_0104, 1'b1, 1'b1, 16'h1357);
    // R2: 0x2F matches regions 1 and 2, region 1 wins
    run(32'h2F00_0000, 1'b0, 1'b0, 16'h0);
    // R2: no region matches
    run(32'h0500_0000, 1'b0, 1'b0, 16'h0);
    run(32'h0500_0000, 1'b1, 1'b1, 16'hFFFF);
    // R8: narrow region 3, split read and write
    run(32'h9000_0031, 1'b0, 1'b1, 16'h0);
    run(32'h9000_0031, 1'b1, 1'b1, 16'hA55A);
    run(32'h9000_0040, 1'b0, 1'b0, 16'h0);
    // R3: maximum counts
    rt[0] = tm(31, 31, 31, 31);
    run(32'h10AB_CDEF, 1'b0, 1'b0, 16'h0);
    wt[0] = tm(31, 31, 31, 31);
    run(32'h10AB_CDF0, 1'b1, 1'b0, 16'h7E81);

    tops[0] = 8'h10; tops[1] = 8'h25; tops[2] = 8'h2F;
    tops[3] = 8'h90; tops[4] = 8'h05; tops[5] = 8'hFF;
    for (int i = 0; i < 60; i++) begin
      int c;
      logic [31:0] a;
      a = {tops[$urandom % 6], 24'($urandom)};
      c = exp_cs(a[31:24]);
      if (c >= 0) begin
        rt[c] = tm($urandom % 5, $urandom % 5, $urandom % 5, $urandom % 5);
        wt[c] = tm($urandom % 5, $urandom % 5, $urandom % 5, $urandom % 5);
      end
      run(a, 1'($urandom), 1'($urandom), 16'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule